// File: doc/BRIEF.md
# Butterfly-to-Scaler Residue Serialiser

This block sits after one modulus channel of a radix-4 butterfly stage in a residue-number FFT pipeline. In a single cycle the butterfly presents a group of eight real residues: the real and imaginary parts of four complex results, numbered 0 to 3. The serialiser holds the group in two levels of registers. It then hands the group to a pair of downstream residue scalers, one complex result per cycle. Because of this, two scalers do the work that would otherwise need eight.

Real parts always leave on the first scaler channel and imaginary parts on the second. Residues pass through bit for bit; no modular arithmetic is done here. A group can be taken at most once every four cycles, which is the rate at which the two channels drain it. A group offered sooner is discarded and flagged. Groups offered exactly four cycles apart give an unbroken stream of output pairs.

Top module: `p2s_scaler_feed`

## Requirements
- R1: After a synchronous reset, out_valid and err_overflow are low and out_re, out_im and out_index are zero. out_valid stays low until a group has been accepted.
- R2: When a group is accepted at a clock edge, its result 0 appears with out_valid high in the output registers updated at the fourth following edge.
- R3: The results of one group leave in four consecutive cycles, with out_index equal to 0, 1, 2 and 3 in that order.
- R4: On each valid cycle, out_re equals the real residue and out_im equals the imaginary residue of result out_index, unchanged. Result k is taken from bits [k*W+W-1 : k*W] of in_re and in_im.
- R5: out_valid is high for exactly four consecutive cycles per accepted group. Groups accepted four cycles apart produce an uninterrupted valid stream.
- R6: An in_valid at any of the three edges that follow an acceptance is rejected. err_overflow is high for the cycle after that edge, and the rejected group produces no output and does not disturb the group in flight.
- R7: An in_valid at an edge when no group is being taken in leaves err_overflow low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A residue group is offered this cycle |
| in_re | input | LANES*W | Real residues of results 0..LANES-1, result k in slice k |
| in_im | input | LANES*W | Imaginary residues of results 0..LANES-1, result k in slice k |
| out_valid | output | 1 | out_re/out_im carry a result for the scalers |
| out_index | output | $clog2(LANES) | Number of the result being presented |
| out_re | output | W | Real residue to scaler channel 1 |
| out_im | output | W | Imaginary residue to scaler channel 2 |
| err_overflow | output | 1 | Previous-edge group was rejected as too early |

## Verification
A fault in the acceptance counter shows within one cycle, as a wrong err_overflow after an early or a legal in_valid. It shows four cycles later as a missing or extra burst of out_valid. A wrong skew depth or a wrong lane select shows as a wrong residue on out_re or out_im during the burst of that very group. A slip in the result counter shows as a broken 0-1-2-3 order or a burst of the wrong length. Because of this, comparing every cycle against a timed queue of expected pairs pins each fault to the cycle where it happens.

// File: rtl/p2s_pkg.sv
package p2s_pkg;

  // Number of delay stages a lane needs after the second register level so
  // that its tail is ready exactly when the output mux reaches it.
  function automatic int unsigned skew_depth(input int unsigned lane,
                                             input int unsigned start_delay);
    return start_delay - 2 + lane;
  endfunction

  // Next result number in a burst; wraps to zero after the last lane.
  function automatic int unsigned next_index(input int unsigned idx,
                                             input int unsigned lanes);
    return (idx == lanes - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/p2s_capture.sv
module p2s_capture #(
  parameter int unsigned W     = 12,
  parameter int unsigned LANES = 4,
  localparam int unsigned BUSW = LANES * W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_l1,
  input  logic            load_l2,
  input  logic [BUSW-1:0] in_re,
  input  logic [BUSW-1:0] in_im,
  output logic [BUSW-1:0] l2_re,
  output logic [BUSW-1:0] l2_im
);

  logic [BUSW-1:0] l1_re, l1_im;

  // First level: grabs the group on acceptance, holds otherwise.
  always_ff @(posedge clk) begin
    if (rst) begin
      l1_re <= '0;
      l1_im <= '0;
    end else if (load_l1) begin
      l1_re <= in_re;
      l1_im <= in_im;
    end
  end

  // Second level: takes the group one cycle later, freeing the first level.
  always_ff @(posedge clk) begin
    if (rst) begin
      l2_re <= '0;
      l2_im <= '0;
    end else if (load_l2) begin
      l2_re <= l1_re;
      l2_im <= l1_im;
    end
  end

endmodule

// File: rtl/p2s_skew.sv
module p2s_skew #(
  parameter int unsigned DW    = 24,
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  logic [DW-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[DEPTH-1];

endmodule

// File: rtl/p2s_sequencer.sv
module p2s_sequencer #(
  parameter int unsigned LANES       = 4,
  parameter int unsigned START_DELAY = 4,
  localparam int unsigned IDXW  = $clog2(LANES),
  localparam int unsigned BUSYW = $clog2(LANES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            accept,
  output logic            reject,
  output logic            load_l2,
  output logic            emit,
  output logic [IDXW-1:0] emit_idx,
  output logic            busy
);
  import p2s_pkg::*;

  logic [BUSYW-1:0]       busy_cnt;
  logic [START_DELAY-1:0] acc_pipe;
  logic [IDXW-1:0]        burst_idx;

  assign busy   = (busy_cnt != '0);
  assign accept = in_valid && !busy;
  assign reject = in_valid && busy;

  // Hold-off window of LANES-1 edges after each acceptance.
  always_ff @(posedge clk) begin
    if (rst)          busy_cnt <= '0;
    else if (accept)  busy_cnt <= BUSYW'(LANES - 1);
    else if (busy)    busy_cnt <= busy_cnt - 1'b1;
  end

  // Acceptance travels down a short pipe to start the burst on time.
  always_ff @(posedge clk) begin
    if (rst) acc_pipe <= '0;
    else     acc_pipe <= {acc_pipe[START_DELAY-2:0], accept};
  end

  assign load_l2  = acc_pipe[0];
  assign emit     = acc_pipe[START_DELAY-1] || (burst_idx != '0);
  assign emit_idx = (burst_idx == '0) ? '0 : burst_idx;

  always_ff @(posedge clk) begin
    if (rst)       burst_idx <= '0;
    else if (emit) burst_idx <= IDXW'(next_index(int'(emit_idx), LANES));
  end

endmodule

// File: rtl/p2s_scaler_feed.sv
module p2s_scaler_feed #(
  parameter int unsigned W           = 12,
  parameter int unsigned LANES       = 4,
  parameter int unsigned START_DELAY = 4,
  localparam int unsigned IDXW = $clog2(LANES),
  localparam int unsigned BUSW = LANES * W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [BUSW-1:0] in_re,
  input  logic [BUSW-1:0] in_im,
  output logic            out_valid,
  output logic [IDXW-1:0] out_index,
  output logic [W-1:0]    out_re,
  output logic [W-1:0]    out_im,
  output logic            err_overflow
);
  import p2s_pkg::*;

  // Named internal events, brought out for the checker.
  logic            accept;
  logic            reject;
  logic            load_l2;
  logic            emit;
  logic [IDXW-1:0] emit_idx;
  logic            busy;

  logic [BUSW-1:0] l2_re, l2_im;
  logic [W-1:0]    tail_re [LANES];
  logic [W-1:0]    tail_im [LANES];

  p2s_sequencer #(.LANES(LANES), .START_DELAY(START_DELAY)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .accept(accept), .reject(reject), .load_l2(load_l2),
    .emit(emit), .emit_idx(emit_idx), .busy(busy)
  );

  p2s_capture #(.W(W), .LANES(LANES)) u_cap (
    .clk(clk), .rst(rst), .load_l1(accept), .load_l2(load_l2),
    .in_re(in_re), .in_im(in_im), .l2_re(l2_re), .l2_im(l2_im)
  );

  // Each result lane gets a delay one stage longer than the lane before it.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [2*W-1:0] lane_out;
    p2s_skew #(.DW(2*W), .DEPTH(skew_depth(k, START_DELAY))) u_skew (
      .clk(clk), .rst(rst),
      .din({l2_re[k*W +: W], l2_im[k*W +: W]}),
      .dout(lane_out)
    );
    assign tail_re[k] = lane_out[2*W-1:W];
    assign tail_im[k] = lane_out[W-1:0];
  end

  // Two output multiplexers: real lanes to channel 1, imaginary to channel 2.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_index    <= '0;
      out_re       <= '0;
      out_im       <= '0;
      err_overflow <= 1'b0;
    end else begin
      out_valid    <= emit;
      err_overflow <= reject;
      if (emit) begin
        out_index <= emit_idx;
        out_re    <= tail_re[emit_idx];
        out_im    <= tail_im[emit_idx];
      end
    end
  end

endmodule

// File: rtl/p2s_checker.sv
module p2s_checker #(
  parameter int unsigned LANES       = 4,
  parameter int unsigned START_DELAY = 4,
  localparam int unsigned IDXW = $clog2(LANES)
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            accept,
  input logic            busy,
  input logic            out_valid,
  input logic [IDXW-1:0] out_index,
  input logic            err_overflow
);

  logic [START_DELAY-1:0] acc_sr;
  always_ff @(posedge clk) begin
    if (rst) acc_sr <= '0;
    else     acc_sr <= {acc_sr[START_DELAY-2:0], accept};
  end

  a_r2_start_latency: assert property (@(posedge clk) disable iff (rst)
    acc_sr[START_DELAY-1] |=> (out_valid && out_index == '0));

  a_r3_index_step: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_index != IDXW'(LANES - 1)) |=>
      (out_valid && out_index == $past(out_index) + 1'b1));

  a_r5_burst_start: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_index == '0);

  a_r6_early_flagged: assert property (@(posedge clk) disable iff (rst)
    (in_valid && busy) |=> err_overflow);

  a_r7_no_false_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !busy) |=> !err_overflow);

endmodule

bind p2s_scaler_feed p2s_checker #(.LANES(LANES), .START_DELAY(START_DELAY)) u_p2s_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .accept(accept), .busy(busy),
  .out_valid(out_valid), .out_index(out_index), .err_overflow(err_overflow)
);

// File: tb/test_p2s_scaler_feed.sv
module test_p2s_scaler_feed;
  localparam int W     = 12;
  localparam int LANES = 4;
  localparam int BUSW  = LANES * W;
  localparam int SLOTS = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [BUSW-1:0] in_re = '0;
  logic [BUSW-1:0] in_im = '0;
  logic            out_valid;
  logic [1:0]      out_index;
  logic [W-1:0]    out_re, out_im;
  logic            err_overflow;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int mbusy  = 0;

  bit         ev   [SLOTS];
  int         eidx [SLOTS];
  logic [W-1:0] ere [SLOTS];
  logic [W-1:0] eim [SLOTS];
  bit         eovf [SLOTS];

  always #2 clk = ~clk;  // 250 MHz

  p2s_scaler_feed #(.W(W), .LANES(LANES)) i_p2s_scaler_feed (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_index(out_index), .out_re(out_re),
    .out_im(out_im), .err_overflow(err_overflow)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // One clock: drive at the falling edge, update the model for the coming
  // edge, then compare all outputs just after that edge.
  task automatic step(input bit v);
    int n;
    logic [BUSW-1:0] re, im;
    for (int k = 0; k < LANES; k++) begin
      re[k*W +: W] = W'($urandom);
      im[k*W +: W] = W'($urandom);
    end
    @(negedge clk);
    in_valid = v; in_re = re; in_im = im;
    n = cyc + 1;
    if (v && mbusy == 0) begin
      for (int k = 0; k < LANES; k++) begin
        ev  [(n + 4 + k) % SLOTS] = 1'b1;
        eidx[(n + 4 + k) % SLOTS] = k;
        ere [(n + 4 + k) % SLOTS] = re[k*W +: W];
        eim [(n + 4 + k) % SLOTS] = im[k*W +: W];
      end
      mbusy = LANES - 1;
    end else begin
      if (v) eovf[n % SLOTS] = 1'b1;
      if (mbusy > 0) mbusy--;
    end
    @(posedge clk);
    cyc = n;
    #1;
    check("R5 out_valid", int'(out_valid), int'(ev[n % SLOTS]));
    if (eovf[n % SLOTS]) check("R6 err_overflow", int'(err_overflow), 1);
    else                 check("R7 err_overflow", int'(err_overflow), 0);
    if (ev[n % SLOTS] && out_valid) begin
      check("R3 out_index", int'(out_index), eidx[n % SLOTS]);
      check("R4 out_re",    int'(out_re),    int'(ere[n % SLOTS]));
      check("R4 out_im",    int'(out_im),    int'(eim[n % SLOTS]));
    end
    ev[n % SLOTS]   = 1'b0;
    eovf[n % SLOTS] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < SLOTS; i++) begin
      ev[i] = 1'b0; eovf[i] = 1'b0; eidx[i] = 0; ere[i] = '0; eim[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 out_valid",    int'(out_valid),    0);
    check("R1 err_overflow", int'(err_overflow), 0);
    check("R1 out_re",       int'(out_re),       0);
    check("R1 out_im",       int'(out_im),       0);
    check("R1 out_index",    int'(out_index),    0);
    @(negedge clk);
    rst = 1'b0;
    // R1: idle after reset, nothing valid
    repeat (6) step(1'b0);
    // R2, R3, R4: single isolated group
    step(1'b1);
    repeat (10) step(1'b0);
    // R5: groups exactly four cycles apart, continuous stream
    for (int g = 0; g < 6; g++) begin
      step(1'b1); repeat (3) step(1'b0);
    end
    repeat (8) step(1'b0);
    // R6: early offers at one, two and three cycles after acceptance
    for (int gap = 1; gap <= 3; gap++) begin
      step(1'b1);
      repeat (gap - 1) step(1'b0);
      step(1'b1);
      repeat (10) step(1'b0);
    end
    // R6 and R7: in_valid held high every cycle
    repeat (24) step(1'b1);
    repeat (10) step(1'b0);
    // Mixed random traffic
    for (int i = 0; i < 300; i++) step(1'(($urandom % 3) == 0));
    repeat (10) step(1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule